// File: doc/BRIEF.md
# Pin Edge Interrupt and Alert Controller

This block watches a group of already-synchronized input lines and turns their level changes into one sticky interrupt. Every pin has two mask bits, one for upward transitions and one for downward ones, so a pin can report rising edges, falling edges, both or neither. The two mask vectors come from whichever register bank is currently active in the surrounding expander. An unmaskable thermal-fault flag feeds the same interrupt. While the interrupt is pending, or while the fault flag is high, the block asserts an active-low drive enable for the open-drain alert wire.

The host finds the interrupting device by reading the bus-wide alert response address. The bus interface passes that read to this block as a request pulse. The block then says whether the device should answer and supplies the 7-bit device address to send back. When the reply byte has gone out, the bus interface pulses a done strobe. It also reports whether arbitration was lost to a device with a lower address. Only a reply that completes without losing arbitration clears the interrupt. A soft reset also clears it.

Top module: `edge_alert_ctrl`

## Requirements
- R1: A 0-to-1 change on pin i whose rise mask bit i is 0 latches the interrupt. `alert_n_o` goes to 0 on the third rising clock edge after the new level is first sampled, and stays 1 on the second.
- R2: A 1-to-0 change on pin i whose fall mask bit i is 0 latches the interrupt with the same latency as R1.
- R3: A mask bit value of 1 suppresses that pin's events in that direction. A pin whose rise mask is 0 but whose fall mask is 1 raises nothing on a falling change.
- R4: While and after synchronous reset, with no new events, `alert_n_o` = 1, `ara_reply_o` = 0 and `ara_addr_o` = 0.
- R5: Once latched, the interrupt stays pending when both mask vectors are later set to all ones.
- R6: One clock edge after an `ara_req_i` pulse, `ara_reply_o` equals 1 if an interrupt is pending and 0 otherwise. When it is 1, `ara_addr_o` holds `own_addr_i`.
- R7: A `ara_done_i` pulse with `ara_lost_i` = 0, after a reply of 1, clears the interrupt. `alert_n_o` returns to 1 two edges after the done edge, if no fault is present.
- R8: A `ara_done_i` pulse with `ara_lost_i` = 1 leaves the interrupt pending and `alert_n_o` at 0.
- R9: A one-cycle `soft_rst_i` pulse clears the pending interrupt.
- R10: The thermal flag cannot be masked. `alert_n_o` drops one edge after it rises. A clear while the flag is high leaves the interrupt pending.
- R11: An unmasked pin event that reaches the latch on the same edge as a clear is kept, and the interrupt stays pending.
- R12: Pin levels held through reset do not count as edges when reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | NPIN | Synchronized pin levels |
| mask_rise_i | input | NPIN | Active-bank rise masks, 1 = masked |
| mask_fall_i | input | NPIN | Active-bank fall masks, 1 = masked |
| therm_fault_i | input | 1 | Thermal fault flag, unmaskable |
| soft_rst_i | input | 1 | Soft reset pulse, clears the interrupt |
| own_addr_i | input | AW | This device's bus address |
| ara_req_i | input | 1 | Alert-response read started |
| ara_done_i | input | 1 | Alert-response reply byte finished |
| ara_lost_i | input | 1 | Arbitration lost during the reply, valid with done |
| ara_reply_o | output | 1 | 1 = answer the alert-response read |
| ara_addr_o | output | AW | Address to return in the reply |
| alert_n_o | output | 1 | Active-low alert drive enable |

## Verification
The assertions take `pin_i` to be synchronized to `clk` already. They also assume the bus interface runs one alert-response transaction at a time: a request, then exactly one done strobe, with `ara_lost_i` meaningful only alongside it. The stimulus changes inputs just after a clock edge and always pairs each request with a single done pulse. It drops the fault flag and the pin levels only once the bus has gone quiet, so every edge the bench creates is one the requirements define.

// File: rtl/eac_pkg.sv
package eac_pkg;
  typedef enum logic [0:0] {
    ARA_IDLE  = 1'b0,
    ARA_ARMED = 1'b1
  } ara_state_e;
endpackage

// File: rtl/eac_edge_track.sv
module eac_edge_track #(
  parameter int unsigned NPIN = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NPIN-1:0] pin_i,
  output logic [NPIN-1:0] rise_o,
  output logic [NPIN-1:0] fall_o
);
  logic [NPIN-1:0] prev_q;

  // History follows the pins during reset too, so held levels are no edges.
  always_ff @(posedge clk) begin
    prev_q <= pin_i;
  end

  for (genvar g = 0; g < NPIN; g++) begin : g_cmp
    assign rise_o[g] = pin_i[g] & ~prev_q[g];
    assign fall_o[g] = ~pin_i[g] & prev_q[g];
  end

  assert_prime_R12: assert property (@(posedge clk) rst |=> (rise_o == '0 || !$stable(pin_i)))
    else $error("history not primed from pins during reset");
endmodule

// File: rtl/eac_event_gate.sv
module eac_event_gate #(
  parameter int unsigned NPIN = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NPIN-1:0] rise_i,
  input  logic [NPIN-1:0] fall_i,
  input  logic [NPIN-1:0] mask_rise_i,
  input  logic [NPIN-1:0] mask_fall_i,
  output logic            any_o
);
  logic [NPIN-1:0] hit_d;
  logic [NPIN-1:0] hit_q;

  for (genvar g = 0; g < NPIN; g++) begin : g_mask
    assign hit_d[g] = (rise_i[g] & ~mask_rise_i[g]) | (fall_i[g] & ~mask_fall_i[g]);
  end

  always_ff @(posedge clk) begin
    if (rst) hit_q <= '0;
    else     hit_q <= hit_d;
  end

  assign any_o = |hit_q;

  assert_masked_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    ((&mask_rise_i) && (&mask_fall_i)) |=> !any_o)
    else $error("event passed a fully masked bank");
endmodule

// File: rtl/eac_alert_latch.sv
module eac_alert_latch (
  input  logic clk,
  input  logic rst,
  input  logic event_i,
  input  logic therm_i,
  input  logic clear_i,
  input  logic soft_clr_i,
  output logic pend_o,
  output logic alert_n_o
);
  logic pend_q;
  logic pend_d;
  logic alert_n_q;

  // Set terms win over clear terms.
  always_comb begin
    pend_d = pend_q & ~(clear_i | soft_clr_i);
    if (event_i || therm_i) pend_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q    <= 1'b0;
      alert_n_q <= 1'b1;
    end else begin
      pend_q    <= pend_d;
      alert_n_q <= ~(pend_q | therm_i);
    end
  end

  assign pend_o    = pend_q;
  assign alert_n_o = alert_n_q;

  assert_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    (pend_q && !clear_i && !soft_clr_i) |=> pend_q)
    else $error("interrupt lost without a clear");

  assert_event_kept_R11: assert property (@(posedge clk) disable iff (rst)
    event_i |=> pend_q)
    else $error("event dropped");

  assert_therm_alert_R10: assert property (@(posedge clk) disable iff (rst)
    therm_i |=> (pend_q && !alert_n_o))
    else $error("thermal fault not signalled");

  assert_clear_R7: assert property (@(posedge clk) disable iff (rst)
    ((clear_i || soft_clr_i) && !event_i && !therm_i) |=> !pend_q)
    else $error("clear did not take effect");
endmodule

// File: rtl/eac_ara_resp.sv
module eac_ara_resp
  import eac_pkg::*;
#(
  parameter int unsigned AW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_i,
  input  logic          done_i,
  input  logic          lost_i,
  input  logic          pend_i,
  input  logic [AW-1:0] own_addr_i,
  output logic          reply_o,
  output logic [AW-1:0] addr_o,
  output logic          clear_o
);
  ara_state_e    state_q;
  logic          reply_q;
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ARA_IDLE;
      reply_q <= 1'b0;
      addr_q  <= '0;
    end else begin
      case (state_q)
        ARA_IDLE: begin
          if (req_i) begin
            reply_q <= pend_i;
            if (pend_i) begin
              addr_q  <= own_addr_i;
              state_q <= ARA_ARMED;
            end
          end
        end
        default: begin
          if (done_i) begin
            reply_q <= 1'b0;
            state_q <= ARA_IDLE;
          end
        end
      endcase
    end
  end

  assign clear_o = (state_q == ARA_ARMED) & done_i & ~lost_i;
  assign reply_o = reply_q;
  assign addr_o  = addr_q;

  assert_silent_idle_R6: assert property (@(posedge clk) disable iff (rst)
    (req_i && !pend_i && state_q == ARA_IDLE) |=> !reply_o)
    else $error("replied with nothing pending");

  assert_reply_addr_R6: assert property (@(posedge clk) disable iff (rst)
    (req_i && pend_i && state_q == ARA_IDLE) |=> (reply_o && addr_o == $past(own_addr_i)))
    else $error("reply or address missing");
endmodule

// File: rtl/edge_alert_ctrl.sv
module edge_alert_ctrl #(
  parameter int unsigned NPIN = 8,
  parameter int unsigned AW   = 7
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NPIN-1:0] pin_i,
  input  logic [NPIN-1:0] mask_rise_i,
  input  logic [NPIN-1:0] mask_fall_i,
  input  logic            therm_fault_i,
  input  logic            soft_rst_i,
  input  logic [AW-1:0]   own_addr_i,
  input  logic            ara_req_i,
  input  logic            ara_done_i,
  input  logic            ara_lost_i,
  output logic            ara_reply_o,
  output logic [AW-1:0]   ara_addr_o,
  output logic            alert_n_o
);
  logic [NPIN-1:0] rise_w;
  logic [NPIN-1:0] fall_w;
  logic            event_w;
  logic            pend_w;
  logic            clear_w;

  eac_edge_track #(.NPIN(NPIN)) edge_i (
    .clk(clk), .rst(rst), .pin_i(pin_i), .rise_o(rise_w), .fall_o(fall_w)
  );

  eac_event_gate #(.NPIN(NPIN)) gate_i (
    .clk(clk), .rst(rst), .rise_i(rise_w), .fall_i(fall_w),
    .mask_rise_i(mask_rise_i), .mask_fall_i(mask_fall_i), .any_o(event_w)
  );

  eac_alert_latch latch_i (
    .clk(clk), .rst(rst), .event_i(event_w), .therm_i(therm_fault_i),
    .clear_i(clear_w), .soft_clr_i(soft_rst_i), .pend_o(pend_w), .alert_n_o(alert_n_o)
  );

  eac_ara_resp #(.AW(AW)) ara_i (
    .clk(clk), .rst(rst), .req_i(ara_req_i), .done_i(ara_done_i), .lost_i(ara_lost_i),
    .pend_i(pend_w), .own_addr_i(own_addr_i), .reply_o(ara_reply_o),
    .addr_o(ara_addr_o), .clear_o(clear_w)
  );

  assert_lost_keeps_R8: assert property (@(posedge clk) disable iff (rst)
    (pend_w && ara_done_i && ara_lost_i && !soft_rst_i) |=> pend_w)
    else $error("lost arbitration cleared the interrupt");

  assert_alert_follows_R1: assert property (@(posedge clk) disable iff (rst)
    (pend_w || therm_fault_i) |=> !alert_n_o)
    else $error("alert not driven while pending");
endmodule

// File: tb/edge_alert_ctrl_tb_top.sv
module edge_alert_ctrl_tb_top;
  localparam int unsigned NPIN = 8;
  localparam int unsigned AW   = 7;

  logic            clk = 1'b0;
  logic            rst;
  logic [NPIN-1:0] pin_i, mask_rise_i, mask_fall_i;
  logic            therm_fault_i, soft_rst_i, ara_req_i, ara_done_i, ara_lost_i;
  logic [AW-1:0]   own_addr_i;
  logic            ara_reply_o, alert_n_o;
  logic [AW-1:0]   ara_addr_o;

  int n_chk  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  edge_alert_ctrl #(.NPIN(NPIN), .AW(AW)) dut_i (
    .clk(clk), .rst(rst), .pin_i(pin_i), .mask_rise_i(mask_rise_i), .mask_fall_i(mask_fall_i),
    .therm_fault_i(therm_fault_i), .soft_rst_i(soft_rst_i), .own_addr_i(own_addr_i),
    .ara_req_i(ara_req_i), .ara_done_i(ara_done_i), .ara_lost_i(ara_lost_i),
    .ara_reply_o(ara_reply_o), .ara_addr_o(ara_addr_o), .alert_n_o(alert_n_o)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic apply_reset(input logic [NPIN-1:0] p, input logic [NPIN-1:0] mr,
                             input logic [NPIN-1:0] mf);
    rst = 1'b1; pin_i = p; mask_rise_i = mr; mask_fall_i = mf;
    therm_fault_i = 1'b0; soft_rst_i = 1'b0; ara_req_i = 1'b0;
    ara_done_i = 1'b0; ara_lost_i = 1'b0; own_addr_i = 7'h2C;
    tick(3);
    rst = 1'b0;
    tick(1);
  endtask

  task automatic ara_cycle(input logic lost, output logic rep, output logic [AW-1:0] addr);
    ara_req_i = 1'b1;
    tick(1);
    ara_req_i = 1'b0;
    rep = ara_reply_o;
    addr = ara_addr_o;
    ara_done_i = 1'b1; ara_lost_i = lost;
    tick(1);
    ara_done_i = 1'b0; ara_lost_i = 1'b0;
    tick(1);
  endtask

  task automatic latch_rise(input int pin);
    mask_rise_i = ~(8'h01 << pin);
    pin_i[pin] = 1'b1;
    tick(3);
    mask_rise_i = 8'hFF;
  endtask

  task automatic t_reset;
    chk("R4 alert after reset", alert_n_o, 1);
    chk("R4 reply after reset", ara_reply_o, 0);
    chk("R4 addr after reset", ara_addr_o, 0);
  endtask

  task automatic t_rise;
    logic r; logic [AW-1:0] a;
    mask_rise_i = 8'hFE;
    pin_i = 8'h01;
    tick(2);
    chk("R1 alert not yet at edge 2", alert_n_o, 1);
    tick(1);
    chk("R1 alert at edge 3", alert_n_o, 0);
    ara_cycle(1'b0, r, a);
    chk("R6 reply when pending", r, 1);
    chk("R6 reply address", a, 7'h2C);
    chk("R7 alert released after clear", alert_n_o, 1);
    mask_rise_i = 8'hFF; pin_i = 8'h00;
    tick(2);
  endtask

  task automatic t_fall;
    logic r; logic [AW-1:0] a;
    pin_i = 8'h80;
    tick(2);
    mask_fall_i = 8'h7F;
    pin_i = 8'h00;
    tick(2);
    chk("R2 alert not yet at edge 2", alert_n_o, 1);
    tick(1);
    chk("R2 alert at edge 3", alert_n_o, 0);
    own_addr_i = 7'h5A;
    ara_cycle(1'b0, r, a);
    chk("R6 reply address changed", a, 7'h5A);
    chk("R7 alert released", alert_n_o, 1);
    mask_fall_i = 8'hFF;
    own_addr_i = 7'h2C;
  endtask

  task automatic t_masked;
    logic r; logic [AW-1:0] a;
    pin_i = 8'hFF; tick(1); pin_i = 8'h00; tick(1); pin_i = 8'hA5;
    tick(4);
    chk("R3 fully masked toggles", alert_n_o, 1);
    pin_i = 8'h08; tick(2);
    mask_rise_i = 8'hF7;
    pin_i = 8'h00;
    tick(4);
    chk("R3 fall masked on rise-only pin", alert_n_o, 1);
    mask_rise_i = 8'hFF;
    ara_cycle(1'b0, r, a);
    chk("R6 no reply without pending", r, 0);
    chk("R6 alert still idle", alert_n_o, 1);
  endtask

  task automatic t_mask_change;
    logic r; logic [AW-1:0] a;
    latch_rise(2);
    mask_rise_i = 8'hFF; mask_fall_i = 8'hFF;
    pin_i = 8'h00;
    tick(5);
    chk("R5 alert survives masking", alert_n_o, 0);
    ara_cycle(1'b0, r, a);
    chk("R5 still pending at response", r, 1);
    chk("R7 cleared", alert_n_o, 1);
  endtask

  task automatic t_lost;
    logic r; logic [AW-1:0] a;
    latch_rise(4);
    tick(1);
    ara_cycle(1'b1, r, a);
    chk("R8 reply before losing", r, 1);
    tick(1);
    chk("R8 alert kept after loss", alert_n_o, 0);
    ara_cycle(1'b0, r, a);
    chk("R8 replies again", r, 1);
    chk("R7 clear after won reply", alert_n_o, 1);
    pin_i = 8'h00; tick(2);
  endtask

  task automatic t_soft;
    logic r; logic [AW-1:0] a;
    latch_rise(5);
    tick(1);
    chk("R9 pending before soft reset", alert_n_o, 0);
    soft_rst_i = 1'b1; tick(1); soft_rst_i = 1'b0; tick(1);
    chk("R9 alert after soft reset", alert_n_o, 1);
    ara_cycle(1'b0, r, a);
    chk("R9 nothing pending", r, 0);
    pin_i = 8'h00; tick(2);
  endtask

  task automatic t_therm;
    logic r; logic [AW-1:0] a;
    therm_fault_i = 1'b1;
    tick(1);
    chk("R10 alert one edge after fault", alert_n_o, 0);
    ara_cycle(1'b0, r, a);
    chk("R10 reply under fault", r, 1);
    chk("R10 alert held while hot", alert_n_o, 0);
    therm_fault_i = 1'b0;
    tick(2);
    chk("R10 still latched after cool", alert_n_o, 0);
    ara_cycle(1'b0, r, a);
    chk("R10 reply after cool", r, 1);
    chk("R10 alert released after cool clear", alert_n_o, 1);
  endtask

  task automatic t_same_cycle;
    logic r; logic [AW-1:0] a;
    latch_rise(0);
    ara_req_i = 1'b1; tick(1); ara_req_i = 1'b0;
    chk("R11 reply armed", ara_reply_o, 1);
    mask_rise_i = 8'hFD;
    pin_i[1] = 1'b1;
    tick(1);
    ara_done_i = 1'b1; tick(1); ara_done_i = 1'b0;
    tick(1);
    chk("R11 event kept over clear", alert_n_o, 0);
    mask_rise_i = 8'hFF;
    pin_i = 8'h00; tick(2);
    ara_cycle(1'b0, r, a);
    chk("R11 still pending", r, 1);
    chk("R11 clears afterwards", alert_n_o, 1);
  endtask

  task automatic t_prime;
    logic r; logic [AW-1:0] a;
    apply_reset(8'hFF, 8'h00, 8'h00);
    tick(4);
    chk("R12 no edge from held levels", alert_n_o, 1);
    pin_i = 8'h00;
    tick(3);
    chk("R12 real fall still seen", alert_n_o, 0);
    ara_cycle(1'b0, r, a);
    chk("R12 cleared", alert_n_o, 1);
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    apply_reset(8'h00, 8'hFF, 8'hFF);
    t_reset();
    t_rise();
    t_fall();
    t_masked();
    t_mask_change();
    t_lost();
    t_soft();
    t_therm();
    t_same_cycle();
    t_prime();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule